// File: doc/BRIEF.md
# Multi-Mode Timer/Counter Unit

This block is a count register pair, a low byte and a high byte, that advances either on every clock cycle (timer source) or on each falling edge of an external pin (counter source). A two-bit mode field reshapes the pair into one of four arrangements:
- a 13-bit counter, where a 5-bit prescaler in the low byte feeds the high byte;
- a full 16-bit counter;
- an 8-bit counter whose low byte reloads from the high byte when it wraps;
- a split arrangement of two independent 8-bit counters, each with its own run bit and overflow flag.

Software loads either byte through a shared data bus with one write strobe per byte. Each wrap of the active counter sets an overflow flag. The flag stays set until the interrupt controller pulses the matching clear strobe on vectoring to the handler. The external pin is brought into the clock domain through a two-flop synchronizer before its falling edges are detected. The split arrangement exists only in instances built with `SPLIT_EN = 1`.

All pins are plain control and status signals; there is no streaming data path, so no back-pressure applies.

Top module: `tmr_ctr_unit`

## Requirements
- R1: After reset both count bytes read 0x00 and both overflow flags read 0.
- R2: With `ext_sel_i = 0` and `run_i = 1`, the active counter advances by one on every clock edge; with `run_i = 0` and no write, the count bytes hold their value.
- R3: With `ext_sel_i = 1`, the active counter advances once per 1-to-0 transition of `ext_pin_i`. The new count is visible after the third clock edge following the pin change. Rising transitions have no effect.
- R4: Mode 2'b01 is a 16-bit counter with the low byte carrying into the high byte. A step from 0xFFFF to 0x0000 sets `ovf_o`.
- R5: Mode 2'b00 is a 13-bit counter in which the low byte bits 4:0 form a prescaler. The high byte advances when bits 4:0 wrap from 0x1F to 0. Overflow sets `ovf_o` when the high byte wraps from 0xFF. Low byte bits 7:5 keep their written value.
- R6: Mode 2'b10 counts in the low byte only. A step from 0xFF loads the low byte from the high byte and sets `ovf_o`. The high byte is never changed by counting.
- R7: Mode 2'b11 (when `SPLIT_EN = 1`) has two counters:
  - the low byte counts the selected source under `run_i` and sets `ovf_o` on wrap from 0xFF;
  - the high byte counts clock cycles under `run_hi_i` and sets `ovf2_o` on wrap from 0xFF.
- R8: With `SPLIT_EN = 0`, mode 2'b11 stops all counting: both bytes hold.
- R9: `wr_lo_i` or `wr_hi_i` loads `wr_data_i` into the addressed byte at the next edge. In a cycle with any write, no counting occurs and no flag is set.
- R10: An overflow flag stays set until its own clear strobe is pulsed (`ovf_clr_i` for `ovf_o`, `ovf2_clr_i` for `ovf2_o`). An overflow in the same cycle as the clear leaves the flag set.
- R11: Outside mode 2'b11, `run_hi_i` has no effect: the count holds and `ovf2_o` is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Counting arrangement: 00 13-bit, 01 16-bit, 10 8-bit reload, 11 split |
| ext_sel_i | input | 1 | 1 = count pin falling edges, 0 = count clock cycles |
| run_i | input | 1 | Enables the main (or split low) counter |
| run_hi_i | input | 1 | Enables the split high counter in mode 11 |
| wr_lo_i | input | 1 | Load strobe for the low byte |
| wr_hi_i | input | 1 | Load strobe for the high byte |
| wr_data_i | input | 8 | Data loaded by the write strobes |
| ext_pin_i | input | 1 | Asynchronous external event pin |
| ovf_clr_i | input | 1 | Clears `ovf_o` |
| ovf2_clr_i | input | 1 | Clears `ovf2_o` |
| cnt_lo_o | output | 8 | Low count byte |
| cnt_hi_o | output | 8 | High count byte |
| ovf_o | output | 1 | Overflow flag of the main counter |
| ovf2_o | output | 1 | Overflow flag of the split high counter |

## Verification
Timer counting, writes and flag changes are due one clock edge after the cycle that carries the stimulus. A pin transition reaches the count only after the third edge. The bench drives every input on a falling clock edge and samples on a later falling edge, counting the rising edges in between. For the pin path it checks that the count is still unchanged after two edges and has moved after the third.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_PRESCALE = 2'b00,
    MODE_WIDE     = 2'b01,
    MODE_RELOAD   = 2'b10,
    MODE_SPLIT    = 2'b11
  } tmr_mode_e;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      hist_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall_o = hist_q & ~sync_q[SYNC_STAGES-1];

  // R3: one pin transition yields a single-cycle event
  p_single_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/tmr_ovf_flag.sv
module tmr_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int PRE_W    = 5,
  parameter bit SPLIT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_mode_e         mode_i,
  input  logic              tick_i,
  input  logic              run_hi_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] lo_o,
  output logic [BYTE_W-1:0] hi_o,
  output logic              ev_main_o,
  output logic              ev_hi_o
);
  localparam int WIDE_W = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] BYTE_ONE = BYTE_W'(1);
  localparam logic [PRE_W-1:0]  PRE_ONE  = PRE_W'(1);
  localparam logic [WIDE_W-1:0] WIDE_ONE = WIDE_W'(1);

  logic [BYTE_W-1:0] lo_q, hi_q, lo_n, hi_n;
  logic              wr_any;

  assign wr_any = wr_lo_i | wr_hi_i;

  always_comb begin
    lo_n      = lo_q;
    hi_n      = hi_q;
    ev_main_o = 1'b0;
    ev_hi_o   = 1'b0;
    if (wr_any) begin
      if (wr_lo_i) lo_n = wr_data_i;
      if (wr_hi_i) hi_n = wr_data_i;
    end else begin
      unique case (mode_i)
        MODE_PRESCALE: if (tick_i) begin
          lo_n[PRE_W-1:0] = lo_q[PRE_W-1:0] + PRE_ONE;
          if (lo_q[PRE_W-1:0] == '1) begin
            hi_n      = hi_q + BYTE_ONE;
            ev_main_o = (hi_q == '1);
          end
        end
        MODE_WIDE: if (tick_i) begin
          {hi_n, lo_n} = {hi_q, lo_q} + WIDE_ONE;
          ev_main_o    = ({hi_q, lo_q} == '1);
        end
        MODE_RELOAD: if (tick_i) begin
          if (lo_q == '1) begin
            lo_n      = hi_q;
            ev_main_o = 1'b1;
          end else begin
            lo_n = lo_q + BYTE_ONE;
          end
        end
        MODE_SPLIT: if (SPLIT_EN) begin
          if (tick_i) begin
            lo_n      = lo_q + BYTE_ONE;
            ev_main_o = (lo_q == '1);
          end
          if (run_hi_i) begin
            hi_n    = hi_q + BYTE_ONE;
            ev_hi_o = (hi_q == '1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  p_inc_wide_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_WIDE && tick_i && !wr_any) |=>
      {hi_q, lo_q} == $past({hi_q, lo_q}) + WIDE_ONE);
  p_upper_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_PRESCALE && !wr_any) |=>
      lo_q[BYTE_W-1:PRE_W] == $past(lo_q[BYTE_W-1:PRE_W]));
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_RELOAD && tick_i && !wr_any && lo_q == '1) |=>
      (lo_q == $past(hi_q)) && $stable(hi_q));
  p_load_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_i |=> lo_q == $past(wr_data_i));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !run_hi_i && !wr_any) |=> ($stable(lo_q) && $stable(hi_q)));
  p_no_hi_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != MODE_SPLIT) |-> !ev_hi_o);
endmodule

// File: rtl/tmr_ctr_unit.sv
module tmr_ctr_unit
  import tmr_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int PRE_W       = 5,
  parameter int SYNC_STAGES = 2,
  parameter bit SPLIT_EN    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              ext_sel_i,
  input  logic              run_i,
  input  logic              run_hi_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              ext_pin_i,
  input  logic              ovf_clr_i,
  input  logic              ovf2_clr_i,
  output logic [BYTE_W-1:0] cnt_lo_o,
  output logic [BYTE_W-1:0] cnt_hi_o,
  output logic              ovf_o,
  output logic              ovf2_o
);
  localparam int NUM_FLAGS = 2;

  tmr_mode_e            mode;
  logic                 pin_fall, tick;
  logic [NUM_FLAGS-1:0] ev, clr, flg;

  assign mode = tmr_mode_e'(mode_i);

  tmr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_pin_i), .fall_o(pin_fall)
  );

  assign tick = run_i & (ext_sel_i ? pin_fall : 1'b1);

  tmr_count_core #(.BYTE_W(BYTE_W), .PRE_W(PRE_W), .SPLIT_EN(SPLIT_EN)) u_core (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .tick_i(tick),
    .run_hi_i(run_hi_i), .wr_lo_i(wr_lo_i), .wr_hi_i(wr_hi_i),
    .wr_data_i(wr_data_i), .lo_o(cnt_lo_o), .hi_o(cnt_hi_o),
    .ev_main_o(ev[0]), .ev_hi_o(ev[1])
  );

  assign clr = {ovf2_clr_i, ovf_clr_i};

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    tmr_ovf_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(ev[g]), .clr_i(clr[g]), .flag_o(flg[g])
    );
  end

  assign ovf_o  = flg[0];
  assign ovf2_o = flg[1];

  p_no_event_on_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo_i || wr_hi_i) |-> (ev == '0));
  p_split_off_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!SPLIT_EN && mode == MODE_SPLIT && !wr_lo_i && !wr_hi_i) |=>
      ($stable(cnt_lo_o) && $stable(cnt_hi_o)));
endmodule

// File: tb/tb_tmr_ctr_unit.sv
module tb_tmr_ctr_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b01;
  logic       ext_sel = 0, run = 0, run_hi = 0, wr_lo = 0, wr_hi = 0;
  logic [7:0] wr_data = '0;
  logic       pin = 1'b1, ovf_clr = 0, ovf2_clr = 0;
  logic [7:0] lo, hi, ns_lo, ns_hi;
  logic       ovf, ovf2, ns_ovf, ns_ovf2;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_ctr_unit dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .ext_sel_i(ext_sel), .run_i(run),
    .run_hi_i(run_hi), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wr_data_i(wr_data),
    .ext_pin_i(pin), .ovf_clr_i(ovf_clr), .ovf2_clr_i(ovf2_clr),
    .cnt_lo_o(lo), .cnt_hi_o(hi), .ovf_o(ovf), .ovf2_o(ovf2)
  );

  tmr_ctr_unit #(.SPLIT_EN(1'b0)) dut_ns (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .ext_sel_i(ext_sel), .run_i(run),
    .run_hi_i(run_hi), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wr_data_i(wr_data),
    .ext_pin_i(pin), .ovf_clr_i(ovf_clr), .ovf2_clr_i(ovf2_clr),
    .cnt_lo_o(ns_lo), .cnt_hi_o(ns_hi), .ovf_o(ns_ovf), .ovf2_o(ns_ovf2)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] l, input logic [7:0] h);
    wr_lo = 1; wr_data = l; @(negedge clk);
    wr_lo = 0; wr_hi = 1; wr_data = h; @(negedge clk);
    wr_hi = 0;
  endtask

  task automatic clear_flags();
    ovf_clr = 1; ovf2_clr = 1; @(negedge clk);
    ovf_clr = 0; ovf2_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1 lo", lo, 8'h00); chk("R1 hi", hi, 8'h00);
    chk("R1 ovf", ovf, 0);   chk("R1 ovf2", ovf2, 0);
  endtask

  task automatic t_timer_run();
    mode = 2'b01; load(8'h00, 8'h00);
    run = 1; cyc(10); run = 0;
    chk("R2 ten clocks", {hi, lo}, 16'h000A);
    cyc(5);
    chk("R2 hold when stopped", {hi, lo}, 16'h000A);
  endtask

  task automatic t_wide();
    mode = 2'b01; clear_flags(); load(8'hFF, 8'h12);
    run = 1; cyc(1); run = 0;
    chk("R4 carry", {hi, lo}, 16'h1300); chk("R4 no ovf", ovf, 0);
    load(8'hFE, 8'hFF);
    run = 1; cyc(1);
    chk("R4 ffff", {hi, lo}, 16'hFFFF);
    cyc(1); run = 0;
    chk("R4 wrap", {hi, lo}, 16'h0000); chk("R4 ovf set", ovf, 1);
    ovf_clr = 1; cyc(1); ovf_clr = 0;
    chk("R10 cleared", ovf, 0);
  endtask

  task automatic t_counter();
    mode = 2'b01; ext_sel = 1; load(8'h00, 8'h00);
    run = 1; pin = 0; cyc(2);
    chk("R3 not yet after two edges", lo, 8'h00);
    cyc(1);
    chk("R3 counted after third edge", lo, 8'h01);
    pin = 1; cyc(6);
    chk("R3 rising edge ignored", lo, 8'h01);
    for (int i = 0; i < 4; i++) begin
      pin = 0; cyc(4); pin = 1; cyc(4);
    end
    chk("R3 five falls", {hi, lo}, 16'h0005);
    run = 0; ext_sel = 0;
  endtask

  task automatic t_prescale();
    mode = 2'b00; clear_flags(); load(8'hFE, 8'hFF);
    run = 1; cyc(1);
    chk("R5 step", {hi, lo}, 16'hFFFF);
    cyc(1); run = 0;
    chk("R5 wrap keeps bits 7:5", {hi, lo}, 16'h00E0);
    chk("R5 ovf", ovf, 1);
    load(8'h00, 8'h00);
    run = 1; cyc(32); run = 0;
    chk("R5 prescale 32", {hi, lo}, 16'h0100);
  endtask

  task automatic t_reload();
    mode = 2'b10; clear_flags(); load(8'hFD, 8'hF0);
    run = 1; cyc(2);
    chk("R6 before wrap", lo, 8'hFF); chk("R6 no ovf yet", ovf, 0);
    cyc(1); run = 0;
    chk("R6 reloaded", lo, 8'hF0); chk("R6 hi kept", hi, 8'hF0);
    chk("R6 ovf", ovf, 1);
    clear_flags();
    run = 1; cyc(16); run = 0;
    chk("R6 second reload", lo, 8'hF0); chk("R6 ovf again", ovf, 1);
  endtask

  task automatic t_split();
    mode = 2'b11; clear_flags(); load(8'hFE, 8'hFD);
    run = 1; cyc(2); run = 0;
    chk("R7 lo wrap", lo, 8'h00); chk("R7 ovf", ovf, 1);
    chk("R7 hi idle", hi, 8'hFD); chk("R7 ovf2 clear", ovf2, 0);
    run_hi = 1; cyc(3); run_hi = 0;
    chk("R7 hi wrap", hi, 8'h00); chk("R7 ovf2", ovf2, 1);
    chk("R7 lo independent", lo, 8'h00);
    chk("R8 no split lo", ns_lo, 8'hFE); chk("R8 no split hi", ns_hi, 8'hFD);
    ovf2_clr = 1; cyc(1); ovf2_clr = 0;
    chk("R10 ovf2 cleared", ovf2, 0);
  endtask

  task automatic t_write_prio();
    mode = 2'b01; clear_flags(); load(8'h00, 8'h20);
    run = 1; wr_lo = 1; wr_data = 8'h55; cyc(1); wr_lo = 0;
    chk("R9 write beats count", {hi, lo}, 16'h2055);
    cyc(1); run = 0;
    chk("R9 counts after write", {hi, lo}, 16'h2056);
    load(8'hFF, 8'hFF);
    run = 1; wr_hi = 1; wr_data = 8'h07; cyc(1); wr_hi = 0; run = 0;
    chk("R9 no count on write", {hi, lo}, 16'h07FF);
    chk("R9 no flag on write", ovf, 0);
  endtask

  task automatic t_flag();
    mode = 2'b01; clear_flags(); load(8'hFF, 8'hFF);
    run = 1; ovf_clr = 1; cyc(1); run = 0; ovf_clr = 0;
    chk("R10 set beats clear", ovf, 1);
    cyc(5);
    chk("R10 held", ovf, 1);
    ovf2_clr = 1; cyc(1); ovf2_clr = 0;
    chk("R10 other clear ignored", ovf, 1);
    ovf_clr = 1; cyc(1); ovf_clr = 0;
    chk("R10 own clear", ovf, 0);
  endtask

  task automatic t_runhi_ignored();
    mode = 2'b01; clear_flags(); load(8'h34, 8'h12);
    run_hi = 1; cyc(5); run_hi = 0;
    chk("R11 count held", {hi, lo}, 16'h1234);
    chk("R11 ovf2 clear", ovf2, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    t_reset();
    t_timer_run();
    t_wide();
    t_counter();
    t_prescale();
    t_reload();
    t_split();
    t_write_prio();
    t_flag();
    t_runhi_ignored();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule